// File: doc/BRIEF.md
# Debug System Bus Access Master

This block lets an external debugger reach system memory without involving any processor. Three registers are exposed on a small single-cycle register port: a control/status register, an address register and a data register. The debugger uses them to perform single reads, single writes and streaming block transfers.

On the memory side the block acts as a request/acknowledge bus master. A request is raised, and its address, direction, data and size are held stable until the slave acknowledges. No separate command register exists. Writing the address, reading the data or writing the data starts the next bus access, depending on the enables in the control register. The address can advance by the access size after each successful access. A block read therefore costs one data-register read per word, and a block write costs one data-register write per word.

Errors are sticky. An address or data access that arrives while a transfer is still in flight is refused and recorded. A bus error response or an unsupported size is recorded in a 3-bit code. While either record is set, no new bus access is launched.

Top module: `sba_master`

## Requirements
- R1: After reset, `bus_req` is low, the control register (index 0) reads 0x20 (size field 2, every enable off, no errors), and the address (index 1) and data (index 2) registers read 0.
- R2: The control size field occupies bits [5:4], and the access is 2^size bytes: 2 gives 32-bit, 1 gives 16-bit and 0 gives 8-bit. `bus_size` carries the field for each access. A launch attempted with a size above the widest supported value (2 by default) issues no bus access and sets the error field to 3.
- R3: With read-on-address (control bit 0) set, writing the address register starts a bus read at the written address. The returned data appears in the data register after the acknowledge.
- R4: With read-on-data (control bit 1) set, a data-register read returns the current contents and starts a bus read at the current address.
- R5: With auto-increment (control bit 2) set, the address register advances by 2^size after each access that completes without a bus error.
- R6: Writing the data register starts a bus write of the written value to the current address.
- R7: With read-on-data clear, a data-register read returns the last fetched value and starts no bus access.
- R8: The busy flag (control bit 8) is 1 from the cycle after a launch until the acknowledge. During that time `bus_req` stays high and the request's address, direction and data stay stable.
- R9: An address or data register access that arrives while busy has no effect and sets the sticky busy-error bit (control bit 9). Writing 1 to bit 9 clears it. While it is set, no bus access is launched.
- R10: An acknowledge with `bus_err` high sets the error field (control bits [14:12]) to 2. That access neither increments the address nor updates the data register. While the field is nonzero no bus access is launched, and writing 1 to any of its bits clears it.
- R11: `bus_req` falls in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe, one cycle per access |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register index: 0 control, 1 address, 2 data |
| reg_wdata | input | DATA_W | Register write value |
| reg_rdata | output | DATA_W | Combinational read value of the indexed register |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_we | output | 1 | Bus direction, 1 = write |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_size | output | 2 | Access size as log2 of the byte count |
| bus_ack | input | 1 | Slave acknowledge |
| bus_err | input | 1 | Error response, valid with acknowledge |
| bus_rdata | input | DATA_W | Read data, valid with acknowledge |

## Verification
The trigger paths are exercised separately so that a design which fires on the wrong event cannot pass. A plain address write with read-on-address clear must produce no read. A data read with read-on-data clear must produce no read. A data write must produce a write and never a read. Block read and block write sequences at sizes 0, 1 and 2 check that the address advances by exactly the access size, and that it advances only after completion. The slave's read data depends on the address, so a value fetched from the wrong location is detected. Stretched acknowledge latency makes an access land inside an in-flight transfer to probe the busy-error path. A forced error response checks that the address and data stay put and that later triggers are blocked until the code is cleared.

// File: rtl/sba_pkg.sv
package sba_pkg;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_ADDR = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int BIT_RD_ADDR  = 0;
    localparam int BIT_RD_DATA  = 1;
    localparam int BIT_AUTOINC  = 2;
    localparam int BIT_SIZE_LO  = 4;
    localparam int BIT_BUSY     = 8;
    localparam int BIT_BUSY_ERR = 9;
    localparam int BIT_ERR_LO   = 12;

    localparam logic [1:0] SIZE_RESET = 2'd2;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0,
        ERR_BUS  = 3'd2,
        ERR_SIZE = 3'd3
    } sba_err_e;

    typedef struct packed {
        logic [1:0] size;
        logic       autoinc;
        logic       rd_on_data;
        logic       rd_on_addr;
    } sba_cfg_t;

    function automatic sba_cfg_t cfg_from_word(input logic [15:0] w);
        sba_cfg_t c;
        c.size       = w[BIT_SIZE_LO +: 2];
        c.autoinc    = w[BIT_AUTOINC];
        c.rd_on_data = w[BIT_RD_DATA];
        c.rd_on_addr = w[BIT_RD_ADDR];
        return c;
    endfunction

    function automatic logic [15:0] ctrl_word(input sba_cfg_t c, input logic busy,
                                              input logic busy_err, input sba_err_e err);
        logic [15:0] w;
        w = '0;
        w[BIT_RD_ADDR]        = c.rd_on_addr;
        w[BIT_RD_DATA]        = c.rd_on_data;
        w[BIT_AUTOINC]        = c.autoinc;
        w[BIT_SIZE_LO +: 2]   = c.size;
        w[BIT_BUSY]           = busy;
        w[BIT_BUSY_ERR]       = busy_err;
        w[BIT_ERR_LO +: 3]    = err;
        return w;
    endfunction

endpackage

// File: rtl/sba_csr.sv
module sba_csr
    import sba_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    input  logic        viol,
    input  logic        bus_err_evt,
    input  logic        size_err_evt,
    output sba_cfg_t    cfg,
    output logic        busy_err,
    output sba_err_e    err_code
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '{size: SIZE_RESET, autoinc: 1'b0, rd_on_data: 1'b0, rd_on_addr: 1'b0};
            busy_err <= 1'b0;
            err_code <= ERR_NONE;
        end else begin
            if (cfg_we)
                cfg <= cfg_from_word(cfg_wdata);

            if (viol)
                busy_err <= 1'b1;
            else if (cfg_we && cfg_wdata[BIT_BUSY_ERR])
                busy_err <= 1'b0;

            if (bus_err_evt)
                err_code <= ERR_BUS;
            else if (size_err_evt)
                err_code <= ERR_SIZE;
            else if (cfg_we && |cfg_wdata[BIT_ERR_LO +: 3])
                err_code <= ERR_NONE;
        end
    end

endmodule

// File: rtl/sba_addr_unit.sv
module sba_addr_unit #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic [1:0]        step_size,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] stride;

    always_comb stride = ADDR_W'(1) << step_size;

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (step)
            addr <= addr + stride;
    end

endmodule

// File: rtl/sba_bus_engine.sv
module sba_bus_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              launch_we,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [DATA_W-1:0] launch_data,
    input  logic [1:0]        launch_size,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [1:0]        bus_size,
    output logic              done_ok,
    output logic              done_rd_ok,
    output logic              done_fail
);

    logic done;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_size  <= '0;
        end else if (done) begin
            bus_req <= 1'b0;
        end else if (launch) begin
            bus_req   <= 1'b1;
            bus_we    <= launch_we;
            bus_addr  <= launch_addr;
            bus_wdata <= launch_data;
            bus_size  <= launch_size;
        end
    end

    always_comb begin
        done       = bus_req && bus_ack;
        done_ok    = done && !bus_err;
        done_fail  = done && bus_err;
        done_rd_ok = done_ok && !bus_we;
    end

endmodule

// File: rtl/sba_master.sv
module sba_master
    import sba_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [1:0]        bus_size,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam logic [1:0] MAX_SIZE = 2'($clog2(DATA_W / 8));

    sba_cfg_t          cfg;
    sba_err_e          err_code;
    logic              busy_err;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              busy, blocked, size_ok;
    logic              ctrl_wr, addr_wr, data_wr, data_rd, viol;
    logic              want_rd, want_wr, launch, size_err_evt;
    logic              done_ok, done_rd_ok, done_fail;
    logic [ADDR_W-1:0] launch_addr;

    always_comb begin
        busy    = bus_req;
        blocked = busy_err || (err_code != ERR_NONE);
        size_ok = cfg.size <= MAX_SIZE;

        ctrl_wr = reg_valid && reg_write && (reg_addr == REG_CTRL);
        viol    = reg_valid && busy && (reg_addr == REG_ADDR || reg_addr == REG_DATA);
        addr_wr = reg_valid && !busy && reg_write && (reg_addr == REG_ADDR);
        data_wr = reg_valid && !busy && reg_write && (reg_addr == REG_DATA);
        data_rd = reg_valid && !busy && !reg_write && (reg_addr == REG_DATA);

        want_rd      = !blocked && ((addr_wr && cfg.rd_on_addr) || (data_rd && cfg.rd_on_data));
        want_wr      = !blocked && data_wr;
        launch       = (want_rd || want_wr) && size_ok;
        size_err_evt = (want_rd || want_wr) && !size_ok;
        launch_addr  = addr_wr ? ADDR_W'(reg_wdata) : addr_q;
    end

    sba_csr i_csr (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (ctrl_wr),
        .cfg_wdata   (reg_wdata[15:0]),
        .viol        (viol),
        .bus_err_evt (done_fail),
        .size_err_evt(size_err_evt),
        .cfg         (cfg),
        .busy_err    (busy_err),
        .err_code    (err_code)
    );

    sba_addr_unit #(.ADDR_W(ADDR_W)) i_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_wr),
        .load_val (ADDR_W'(reg_wdata)),
        .step     (done_ok && cfg.autoinc),
        .step_size(bus_size),
        .addr     (addr_q)
    );

    sba_bus_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_engine (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_we  (want_wr),
        .launch_addr(launch_addr),
        .launch_data(reg_wdata),
        .launch_size(cfg.size),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_size   (bus_size),
        .done_ok    (done_ok),
        .done_rd_ok (done_rd_ok),
        .done_fail  (done_fail)
    );

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (done_rd_ok)
            data_q <= bus_rdata;
        else if (data_wr)
            data_q <= reg_wdata;
    end

    always_comb begin
        case (reg_addr)
            REG_CTRL: reg_rdata = DATA_W'(ctrl_word(cfg, busy, busy_err, err_code));
            REG_ADDR: reg_rdata = DATA_W'(addr_q);
            REG_DATA: reg_rdata = data_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sba_master_chk.sv
module sba_master_chk
    import sba_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_valid,
    input logic [1:0]        reg_addr,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [1:0]        bus_size,
    input logic              busy_err,
    input sba_err_e          err_code
);

    localparam logic [1:0] MAX_SIZE = 2'($clog2(DATA_W / 8));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_req_drop_R11: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_ack |=> !bus_req);

    assert_size_legal_R2: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> bus_size <= MAX_SIZE);

    assert_busy_violation_R9: assert property (@(posedge clk) disable iff (rst)
        reg_valid && bus_req && (reg_addr == REG_ADDR || reg_addr == REG_DATA) |=> busy_err);

    assert_blocked_launch_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> ($past(err_code) == ERR_NONE) && !$past(busy_err));

endmodule

bind sba_master sba_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sba_master_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_valid(reg_valid),
    .reg_addr (reg_addr),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_size (bus_size),
    .busy_err (busy_err),
    .err_code (err_code)
);

// File: tb/test_sba_master.sv
module test_sba_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;
    int lat = 2;
    int lat_cnt = 0;
    int rd_count = 0;
    int wr_count = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] last_wdata = '0;
    logic [1:0]  last_size = '0;
    logic [31:0] err_addr = 32'hDEAD_0000;
    int cycles = 0;

    always #4 clk = ~clk;

    sba_master i_sba_master (
        .clk(clk), .rst(rst),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_size(bus_size),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return a ^ 32'hA5C3_0F00;
    endfunction

    // Slave model: acknowledges after lat cycles, read data depends on address.
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
            bus_err = 1'b0;
        end else if (bus_req) begin
            lat_cnt++;
            if (lat_cnt >= lat) begin
                lat_cnt   = 0;
                bus_ack   = 1'b1;
                bus_err   = (bus_addr == err_addr);
                bus_rdata = mem_val(bus_addr);
                last_addr = bus_addr;
                last_size = bus_size;
                if (bus_we) begin
                    wr_count++;
                    last_wdata = bus_wdata;
                end else begin
                    rd_count++;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60 && bus_req; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check_eq("R1 bus_req", {31'd0, bus_req}, 32'd0);
        reg_rd(2'd0, v); check_eq("R1 ctrl", v, 32'h20);
        reg_rd(2'd1, v); check_eq("R1 addr", v, 32'h0);
        reg_rd(2'd2, v); check_eq("R1 data", v, 32'h0);
    endtask

    task automatic t_single_read();
        logic [31:0] v;
        int rc = rd_count;
        reg_wr(2'd0, 32'h21);
        reg_wr(2'd1, 32'h0000_1000);
        wait_idle();
        check_eq("R3 one read", rd_count - rc, 1);
        check_eq("R3 read addr", last_addr, 32'h1000);
        check_eq("R2 size 32-bit", {30'd0, last_size}, 32'd2);
        check_eq("R11 req low", {31'd0, bus_req}, 32'd0);
        reg_rd(2'd2, v); check_eq("R3 data", v, mem_val(32'h1000));
        reg_rd(2'd1, v); check_eq("R5 no inc when off", v, 32'h1000);
    endtask

    task automatic t_block_read();
        logic [31:0] v;
        int rc;
        reg_wr(2'd0, 32'h27);
        reg_wr(2'd1, 32'h0000_2000);
        wait_idle();
        reg_rd(2'd1, v); check_eq("R5 addr +4", v, 32'h2004);
        reg_rd(2'd2, v); check_eq("R4 first value", v, mem_val(32'h2000));
        wait_idle();
        check_eq("R4 next read addr", last_addr, 32'h2004);
        reg_rd(2'd2, v); check_eq("R4 second value", v, mem_val(32'h2004));
        wait_idle();
        reg_wr(2'd0, 32'h0);
        rc = rd_count;
        reg_rd(2'd2, v); check_eq("R7 last value", v, mem_val(32'h2008));
        repeat (6) @(negedge clk);
        check_eq("R7 no new read", rd_count - rc, 0);
        reg_rd(2'd1, v); check_eq("R7 addr unchanged", v, 32'h200C);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int rc = rd_count;
        int wc = wr_count;
        reg_wr(2'd0, 32'h20);
        reg_wr(2'd1, 32'h0000_3000);
        wait_idle();
        check_eq("R3 no read when off", rd_count - rc, 0);
        reg_wr(2'd2, 32'h1234_5678);
        wait_idle();
        check_eq("R6 one write", wr_count - wc, 1);
        check_eq("R6 write addr", last_addr, 32'h3000);
        check_eq("R6 write data", last_wdata, 32'h1234_5678);
        reg_wr(2'd0, 32'h24);
        reg_wr(2'd2, 32'hAAAA_0001);
        wait_idle();
        check_eq("R6 block addr0", last_addr, 32'h3000);
        reg_wr(2'd2, 32'hAAAA_0002);
        wait_idle();
        check_eq("R6 block addr1", last_addr, 32'h3004);
        check_eq("R6 block data1", last_wdata, 32'hAAAA_0002);
        check_eq("R6 never reads", rd_count - rc, 0);
        reg_rd(2'd1, v); check_eq("R5 addr after block write", v, 32'h3008);
    endtask

    task automatic t_sizes();
        logic [31:0] v;
        int wc;
        reg_wr(2'd0, 32'h14);
        reg_wr(2'd1, 32'h0000_4000);
        reg_wr(2'd2, 32'h11);
        wait_idle();
        check_eq("R2 size 16-bit", {30'd0, last_size}, 32'd1);
        reg_rd(2'd1, v); check_eq("R5 addr +2", v, 32'h4002);
        reg_wr(2'd0, 32'h04);
        reg_wr(2'd2, 32'h22);
        wait_idle();
        check_eq("R2 size 8-bit", {30'd0, last_size}, 32'd0);
        reg_rd(2'd1, v); check_eq("R5 addr +1", v, 32'h4003);
        wc = wr_count;
        reg_wr(2'd0, 32'h34);
        reg_wr(2'd2, 32'h33);
        repeat (4) @(negedge clk);
        check_eq("R2 oversize no access", wr_count - wc, 0);
        reg_rd(2'd0, v); check_eq("R2 size error code", {29'd0, v[14:12]}, 32'd3);
        reg_wr(2'd0, 32'h7020);
        reg_rd(2'd0, v); check_eq("R2 error cleared", v, 32'h20);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        int wc;
        lat = 6;
        reg_wr(2'd0, 32'h21);
        reg_wr(2'd1, 32'h0000_5000);
        reg_rd(2'd0, v); check_eq("R8 busy flag set", {31'd0, v[8]}, 32'd1);
        reg_wr(2'd1, 32'h0000_5555);
        wait_idle();
        reg_rd(2'd0, v);
        check_eq("R8 busy flag clear", {31'd0, v[8]}, 32'd0);
        check_eq("R9 busy error set", {31'd0, v[9]}, 32'd1);
        reg_rd(2'd1, v); check_eq("R9 addr write ignored", v, 32'h5000);
        lat = 2;
        wc = wr_count;
        reg_wr(2'd2, 32'h0BAD_0BAD);
        repeat (4) @(negedge clk);
        check_eq("R9 blocked while set", wr_count - wc, 0);
        reg_wr(2'd0, 32'h220);
        reg_rd(2'd0, v); check_eq("R9 cleared by one", {31'd0, v[9]}, 32'd0);
        reg_wr(2'd2, 32'h600D_600D);
        wait_idle();
        check_eq("R9 write after clear", wr_count - wc, 1);
    endtask

    task automatic t_bus_error();
        logic [31:0] v, d0;
        int wc;
        reg_rd(2'd2, d0);
        reg_wr(2'd0, 32'h25);
        reg_wr(2'd1, err_addr);
        wait_idle();
        reg_rd(2'd0, v); check_eq("R10 error code", {29'd0, v[14:12]}, 32'd2);
        reg_rd(2'd1, v); check_eq("R10 no increment", v, err_addr);
        reg_rd(2'd2, v); check_eq("R10 data kept", v, d0);
        wc = wr_count;
        reg_wr(2'd1, 32'h0000_6000);
        reg_wr(2'd2, 32'h7777_0000);
        repeat (4) @(negedge clk);
        check_eq("R10 blocked", wr_count - wc, 0);
        reg_wr(2'd0, 32'h7025);
        reg_rd(2'd0, v); check_eq("R10 cleared", {29'd0, v[14:12]}, 32'd0);
        reg_wr(2'd2, 32'h7777_0001);
        wait_idle();
        check_eq("R10 write resumes", wr_count - wc, 1);
        check_eq("R10 resume addr", last_addr, 32'h6000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_read();
        t_block_read();
        t_write();
        t_sizes();
        t_busy();
        t_bus_error();
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule